// File: doc/BRIEF.md
# Byte-Serial CRC-16 Frame Appender

The block sits in a transmit path and turns a fixed-length payload into a framed packet protected by a 16-bit check. A pacing pulse (typically one every 10 ms) opens a frame. The block then accepts exactly `PAYLOAD_BYTES` bytes, 53 by default, one per handshake. Each byte is forwarded unchanged to the output stream while the check register absorbs it.

The check register uses the reflected CCITT polynomial (0x8408 in shift-right form). One byte is folded in per clock through a four-level XOR network, so the update fits easily in a short cycle. Once the payload is complete, the block appends the bitwise complement of the register as two bytes, low byte first. By default the frame is 55 bytes long, and its final byte is flagged as last. Between frames the block is idle and accepts no input.

Both streams use valid/ready handshakes. The output is a single registered stage, so downstream backpressure propagates to the input through `in_ready`.

Top module: `crc16_frame_appender`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `in_ready`, `out_valid` and `out_last` are low.
- R2: When idle, the block holds `in_ready` and `out_valid` low whatever `in_valid` does. A `start_tick` seen in an idle cycle opens a new frame.
- R3: A frame accepts exactly `PAYLOAD_BYTES` input bytes and emits them unchanged and in order. After that it accepts no further byte until a new frame opens.
- R4: The check register is preset to 0xFFFF when a frame opens. It changes only on an accepted input byte. For each such byte it applies t = (crc[7:0] ^ d) ^ (that value << 4) truncated to 8 bits, then crc' = (crc >> 8) ^ (t << 8) ^ (t << 3) ^ (t >> 4).
- R5: The two bytes after the payload are ~crc[7:0] and then ~crc[15:8], giving a frame of `PAYLOAD_BYTES`+2 bytes.
- R6: `out_last` is high only with the second trailer byte. After that byte is taken, the block returns to idle in the next cycle.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values in the next cycle.
- R8: A `start_tick` arriving during the payload or trailer of a frame is ignored. The frame's bytes and trailer are unaffected.
- R9: With `PAYLOAD_BYTES`=9, the ASCII bytes "123456789" give the trailer bytes 0x6E then 0x90 (check value 0x906E).
- R10: An input byte accepted in one cycle is presented on `out_data` with `out_valid` high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_tick | input | 1 | Pacing pulse that opens a frame when idle |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input payload byte |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte (payload or trailer) |
| out_last | output | 1 | Marks the final trailer byte |
| out_ready | input | 1 | Downstream accepts the output byte |

## Verification
A corrupted check register or a missed update does not show while the payload is streaming. It appears only in the two trailer bytes, one and two handshakes after the last payload byte. The bench therefore predicts every trailer from its own bitwise CRC and compares every output byte as it is taken.

A byte counter that is off by one shows at once as a payload byte where a trailer byte was expected, or the reverse, and as a misplaced last flag. A state machine that wrongly leaves idle, or wrongly restarts on a mid-frame pulse, shows as `in_ready` rising during idle or as a frame that no longer matches its prediction.

// File: rtl/crc16_frame_pkg.sv
package crc16_frame_pkg;

  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_PRESET = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAYLOAD,
    ST_TRL_LO,
    ST_TRL_HI,
    ST_DRAIN
  } frame_state_e;

  typedef enum logic [1:0] {
    SEL_PAYLOAD,
    SEL_TRL_LO,
    SEL_TRL_HI
  } out_sel_e;

endpackage

// File: rtl/crc16_byte_step.sv
// One byte of the reflected CCITT check, factored into four XOR levels.
module crc16_byte_step
  import crc16_frame_pkg::*;
(
  input  logic [CRC_W-1:0]  crc_q,
  input  logic [BYTE_W-1:0] data_byte,
  output logic [CRC_W-1:0]  crc_next
);

  logic [BYTE_W-1:0] mix_a;
  logic [BYTE_W-1:0] mix_b;

  always_comb begin
    mix_a    = crc_q[BYTE_W-1:0] ^ data_byte;
    mix_b    = mix_a ^ {mix_a[3:0], 4'b0000};
    crc_next = {8'h00, crc_q[CRC_W-1:BYTE_W]}
             ^ {mix_b, 8'h00}
             ^ {5'b00000, mix_b, 3'b000}
             ^ {12'h000, mix_b[7:4]};
  end

endmodule

// File: rtl/crc16_frame_ctrl.sv
// Frame sequencer: idle / payload count / two trailer slots / drain.
module crc16_frame_ctrl
  import crc16_frame_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 53
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start_tick,
  input  logic     in_valid,
  input  logic     out_ready,
  input  logic     out_valid,
  output logic     in_ready,
  output logic     crc_init,
  output logic     crc_en,
  output logic     load_en,
  output out_sel_e load_sel
);

  localparam int CNT_W = (PAYLOAD_BYTES > 1) ? $clog2(PAYLOAD_BYTES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PAYLOAD_BYTES - 1);

  frame_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic slot_free;
  logic take;

  assign slot_free = !out_valid || out_ready;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    in_ready = 1'b0;
    crc_init = 1'b0;
    crc_en   = 1'b0;
    load_en  = 1'b0;
    load_sel = SEL_PAYLOAD;
    take     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_tick) begin
          crc_init = 1'b1;
          cnt_d    = '0;
          state_d  = ST_PAYLOAD;
        end
      end
      ST_PAYLOAD: begin
        in_ready = slot_free;
        take     = in_valid && slot_free;
        crc_en   = take;
        load_en  = take;
        if (take) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) state_d = ST_TRL_LO;
        end
      end
      ST_TRL_LO: begin
        load_sel = SEL_TRL_LO;
        load_en  = slot_free;
        if (slot_free) state_d = ST_TRL_HI;
      end
      ST_TRL_HI: begin
        load_sel = SEL_TRL_HI;
        load_en  = slot_free;
        if (slot_free) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (out_valid && out_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/crc16_out_stage.sv
// Single registered output slot holding a payload or trailer byte.
module crc16_out_stage
  import crc16_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  out_sel_e          load_sel,
  input  logic [BYTE_W-1:0] pay_byte,
  input  logic [CRC_W-1:0]  crc_q,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last
);

  logic [CRC_W-1:0]  crc_inv;
  logic [BYTE_W-1:0] next_byte;

  assign crc_inv = ~crc_q;

  always_comb begin
    unique case (load_sel)
      SEL_TRL_LO: next_byte = crc_inv[BYTE_W-1:0];
      SEL_TRL_HI: next_byte = crc_inv[CRC_W-1:BYTE_W];
      default:    next_byte = pay_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else if (load_en) begin
      out_valid <= 1'b1;
      out_last  <= (load_sel == SEL_TRL_HI);
      out_data  <= next_byte;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end

endmodule

// File: rtl/crc16_frame_appender.sv
module crc16_frame_appender
  import crc16_frame_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 53
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_tick,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  input  logic       out_ready
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_next;
  logic crc_init;
  logic crc_en;
  logic load_en;
  out_sel_e load_sel;

  crc16_byte_step u_step (
    .crc_q     (crc_q),
    .data_byte (in_data),
    .crc_next  (crc_next)
  );

  crc16_frame_ctrl #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_tick (start_tick),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .in_ready   (in_ready),
    .crc_init   (crc_init),
    .crc_en     (crc_en),
    .load_en    (load_en),
    .load_sel   (load_sel)
  );

  crc16_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .load_sel  (load_sel),
    .pay_byte  (in_data),
    .crc_q     (crc_q),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= CRC_PRESET;
    end else if (crc_init) begin
      crc_q <= CRC_PRESET;
    end else if (crc_en) begin
      crc_q <= crc_next;
    end
  end

endmodule

// File: rtl/crc16_frame_checker.sv
module crc16_frame_checker #(
  parameter int PAYLOAD_BYTES = 53
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last
);

  localparam int AW = $clog2(PAYLOAD_BYTES + 1);
  localparam logic [AW-1:0] FULL = AW'(PAYLOAD_BYTES);

  logic [AW-1:0] acc_cnt;

  always_ff @(posedge clk) begin
    if (rst) acc_cnt <= '0;
    else if (out_valid && out_ready && out_last) acc_cnt <= '0;
    else if (in_valid && in_ready) acc_cnt <= acc_cnt + 1'b1;
  end

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && !in_ready && !out_last));

  // R7
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R10
  a_r10_pass_through: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && !out_last && out_data == $past(in_data)));

  // R6
  a_r6_last_then_idle: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> (!out_valid && !in_ready));

  // R3
  a_r3_payload_count: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> (acc_cnt < FULL));

  // R5
  a_r5_trailer_after_payload: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |-> (acc_cnt == FULL));

endmodule

bind crc16_frame_appender crc16_frame_checker #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) u_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/tb_crc16_frame_appender.sv
module tb_crc16_frame_appender;

  localparam int N = 53;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1;
  logic       start_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_last;
  logic       out_ready = 1'b1;

  logic       c_start = 1'b0;
  logic       c_in_valid = 1'b0;
  logic [7:0] c_in_data = 8'h00;
  logic       c_in_ready;
  logic       c_out_valid;
  logic [7:0] c_out_data;
  logic       c_out_last;

  crc16_frame_appender #(.PAYLOAD_BYTES(N)) dut (
    .clk(clk), .rst(rst), .start_tick(start_tick), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
  );

  crc16_frame_appender #(.PAYLOAD_BYTES(9)) dut_chk (
    .clk(clk), .rst(rst), .start_tick(c_start), .in_valid(c_in_valid),
    .in_data(c_in_data), .in_ready(c_in_ready), .out_valid(c_out_valid),
    .out_data(c_out_data), .out_last(c_out_last), .out_ready(1'b1)
  );

  int checks = 0;
  int errors = 0;
  int rdy_mode = 0;
  int frames_started = 0;
  int frames_done = 0;
  logic [8:0] exp_q[$];
  logic [8:0] cap_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [7:0] bytes[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (bytes[k]) begin
      c = c ^ {8'h00, bytes[k]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  // downstream ready pattern
  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = ($urandom % 4) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  // reference monitor, compared every clock
  logic       prev_stall = 1'b0;
  logic [7:0] prev_data = 8'h00;
  logic       prev_last = 1'b0;
  int out_idx = 0;
  int acc_cnt = 0;

  always @(negedge clk) begin
    if (rst) begin
      prev_stall = 1'b0;
      out_idx = 0;
      acc_cnt = 0;
    end else begin
      if (prev_stall) begin
        chk(out_valid == 1'b1, "R7 valid held", out_valid, 1);
        chk(out_data == prev_data, "R7 data held", out_data, prev_data);
        chk(out_last == prev_last, "R7 last held", out_last, prev_last);
      end
      if (frames_done == frames_started) begin
        chk(in_ready == 1'b0, "R2 idle in_ready", in_ready, 0);
        chk(out_valid == 1'b0, "R2 idle out_valid", out_valid, 0);
      end
      if (in_valid && in_ready) begin
        acc_cnt++;
        chk(acc_cnt <= N, "R3 accepted count", acc_cnt, N);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected output byte", out_data, 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          if (out_idx < N)
            chk(out_data == e[7:0], "R3 payload byte", out_data, e[7:0]);
          else
            chk(out_data == e[7:0], "R4 R5 trailer byte", out_data, e[7:0]);
          chk(out_last == e[8], "R6 last flag", out_last, e[8]);
        end
        out_idx++;
        if (out_last) begin
          out_idx = 0;
          acc_cnt = 0;
          frames_done++;
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_last  = out_last;
    end
  end

  always @(negedge clk) begin
    if (!rst && c_out_valid) cap_q.push_back({c_out_last, c_out_data});
  end

  // kind: 0 ramp, 1 random, 2 zeros, 3 ones; gaps on input; tick_at: mid-payload tick index
  task automatic send_frame(input int kind, input bit gaps, input int tick_at, input bit tick_trailer);
    logic [7:0] pay[$];
    logic [15:0] c;
    for (int i = 0; i < N; i++) begin
      case (kind)
        0: pay.push_back(8'(i + 1));
        1: pay.push_back(8'($urandom));
        2: pay.push_back(8'h00);
        default: pay.push_back(8'hFF);
      endcase
    end
    c = ref_crc(pay);
    foreach (pay[k]) exp_q.push_back({1'b0, pay[k]});
    exp_q.push_back({1'b0, ~c[7:0]});
    exp_q.push_back({1'b1, ~c[15:8]});
    start_tick = 1'b1;
    frames_started++;
    @(posedge clk); #2;
    start_tick = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (gaps) begin
        int g;
        g = $urandom % 3;
        in_valid = 1'b0;
        repeat (g) begin @(posedge clk); #2; end
      end
      in_valid = 1'b1;
      in_data = pay[i];
      start_tick = (i == tick_at);  // R8: ignored mid-frame pulse
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
      @(posedge clk); #2;
      start_tick = 1'b0;
      in_valid = 1'b0;
    end
    if (tick_trailer) begin
      rdy_mode = 2;
      start_tick = 1'b1;  // R8: pulse during trailer
      @(posedge clk); #2;
      start_tick = 1'b0;
      repeat (6) begin @(posedge clk); #2; end
      rdy_mode = 1;
    end
    while (frames_done != frames_started) begin @(posedge clk); #2; end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b0, "R1 reset in_ready", in_ready, 0);
    chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    chk(out_last == 1'b0, "R1 reset out_last", out_last, 0);
    @(posedge clk); #2;
    in_valid = 1'b1;  // R2: offered while idle, must not be taken
    repeat (5) begin @(posedge clk); #2; end
    in_valid = 1'b0;

    rdy_mode = 0; send_frame(0, 1'b0, -1, 1'b0);
    rdy_mode = 1; send_frame(1, 1'b1, -1, 1'b0);
    rdy_mode = 1; send_frame(2, 1'b0, 20, 1'b0);
    rdy_mode = 0; send_frame(3, 1'b1, 0, 1'b1);
    rdy_mode = 1; send_frame(1, 1'b0, N - 1, 1'b1);

    in_valid = 1'b1;  // R2 after a frame
    repeat (8) begin @(posedge clk); #2; end
    in_valid = 1'b0;
    chk(exp_q.size() == 0, "R5 all frame bytes seen", exp_q.size(), 0);

    // R9: check value with a 9-byte payload
    cap_q.delete();
    c_start = 1'b1;
    @(posedge clk); #2;
    c_start = 1'b0;
    for (int i = 0; i < 9; i++) begin
      c_in_valid = 1'b1;
      c_in_data = 8'h31 + 8'(i);
      forever begin
        @(negedge clk);
        if (c_in_ready) break;
      end
      @(posedge clk); #2;
    end
    c_in_valid = 1'b0;
    repeat (6) begin @(posedge clk); #2; end
    chk(cap_q.size() == 11, "R9 frame length", cap_q.size(), 11);
    if (cap_q.size() == 11) begin
      chk(cap_q[9] == 9'h06E, "R9 trailer low", cap_q[9], 9'h06E);
      chk(cap_q[10] == 9'h190, "R9 trailer high", cap_q[10], 9'h190);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule